// File: doc/BRIEF.md
# Video-Mode Display Timing Generator

This block produces the raster timing for a panel driven in continuous RGB video mode: horizontal sync, vertical sync, a data-enable strobe and the current pixel column and line. Downstream window-fetch logic uses the column and line counters to decide which pixel to supply. The counters advance only on cycles where the pixel-clock enable input is high, so the block runs from the system clock at any pixel rate up to that clock.

Software sets up the timing through a small word-wide register port. Each timing field holds its count minus one: the active width and height, the front porches, the sync widths and the back porches. Within a line the scan passes through the active pixels, then the front porch, then the sync pulse, then the back porch. Within a frame the lines follow the same order. A TV-output mode keeps the programmed totals but moves the sync pulses to fixed offsets. Horizontal sync then begins 10 pixels after the active pixels end and ends 92 pixels before the end of the line. Vertical sync becomes a single line that starts one line after the active lines.

Output runs only while both the output-enable and the frame-enable bits are set. When either bit is cleared, the current frame finishes before the generator stops. A status bit shows whether the generator is still running. A frame-start pending flag, cleared by writing a one to it, drives the interrupt line.

Top module: `vid_timing_gen`

Register map (address: content). 0: control. Bit 0 is output enable, bit 1 is frame enable, bit 2 selects TV mode, bit 3 is the frame-start interrupt enable. 1: status. Bit 0 is the frame-start pending flag, cleared by writing 1. Bit 1 is the running flag, read-only. 8 to 15: timing fields, each held minus one in the low CW bits. In order these are active width, active height, horizontal front porch, vertical front porch, horizontal sync width, vertical sync width, horizontal back porch and vertical back porch. Other addresses read as zero.

## Requirements
- R1: With fields stored minus one, a line lasts (HACT+1)+(HFP+1)+(HSW+1)+(HBP+1) pixel-enable steps, and a frame lasts the same sum of the vertical fields in lines. pos_x counts 0 up to line length minus 1 and then wraps. pos_y advances when pos_x wraps.
- R2: de is high exactly when the generator runs with pos_x below the active width and pos_y below the active height.
- R3: In normal mode (control bit 2 = 0), hsync is high for pos_x in [width+hfp, width+hfp+hsw). vsync is high for pos_y in [height+vfp, height+vfp+vsw). Here width, height, hfp, hfp and the others are the true counts. Both syncs are active-high.
- R4: In TV mode, hsync is high for pos_x in [width+10, line_length-92).
- R5: In TV mode, vsync is high for pos_y in [height+1, height+2).
- R6: The generator starts at pos (0,0) on the clock after both enable bits (control bits 0 and 1) are seen set. Either bit alone does not start it. While it runs, the counters change only on pixel-enable cycles.
- R7: Clearing an enable bit lets the current frame finish. The generator then stops after the last pixel of the frame. While stopped, hsync, vsync and de are low and pos_x and pos_y are 0.
- R8: Status bit 1 reads 1 while the generator runs, including the tail of a frame after disable. It reads 0 once the generator has stopped.
- R9: With control bit 3 set, status bit 0 becomes 1 on the clock after the first pixel step of each frame. irq follows it. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. With control bit 3 clear, the bit is not set.
- R10: When a frame start and a clearing write to status bit 0 fall in the same cycle, the bit ends up set.
- R11: After reset all registers read 0. The control register reads back bits 3:0 as written. A timing field reads back the low CW bits of the written data, and the bits above are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; one scan step per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| hsync | output | 1 | Horizontal sync, active-high |
| vsync | output | 1 | Vertical sync, active-high |
| de | output | 1 | Data enable, high inside the active area |
| pos_x | output | CW+3 | Current pixel column |
| pos_y | output | CW+3 | Current line |
| irq | output | 1 | Frame-start interrupt, equals the pending flag |

## Verification
Two functions can land in the same cycle, and the bench forces both. The first is setting the frame-start pending flag and clearing it by a write of one. The bench positions the scan at pixel (0,0) and issues the clearing write together with the pixel-enable step that opens the frame. It then expects the flag to read set, and expects a later plain clearing write to work. The second is the stop request and the scan itself. The bench clears the output enable mid-frame and tracks the running flag to the last pixel. It expects the flag to stay 1 through the final step and to be 0 one step later, with all strobes low and the counters back at zero.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   localparam int unsigned REG_AW = 4;
   localparam int unsigned REG_DW = 16;

   localparam logic [REG_AW-1:0] ADR_CTRL = 4'd0;
   localparam logic [REG_AW-1:0] ADR_STAT = 4'd1;

   // timing fields live at 8..15; index = addr[2:0]
   localparam int unsigned F_HACT = 0;
   localparam int unsigned F_VACT = 1;
   localparam int unsigned F_HFP  = 2;
   localparam int unsigned F_VFP  = 3;
   localparam int unsigned F_HSW  = 4;
   localparam int unsigned F_VSW  = 5;
   localparam int unsigned F_HBP  = 6;
   localparam int unsigned F_VBP  = 7;
   localparam int unsigned NFIELD = 8;

   typedef struct packed {
      logic irq_en;
      logic tv_mode;
      logic frame_en;
      logic out_en;
   } ctrl_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
   import vtg_pkg::*;
#(
   parameter int unsigned CW = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [REG_AW-1:0]             addr,
   input  logic [REG_DW-1:0]             wdata,
   output logic [REG_DW-1:0]             rdata,
   input  logic                          set_pend,
   input  logic                          running,
   output ctrl_t                         ctrl_q,
   output logic [NFIELD-1:0][CW-1:0]     fld_q,
   output logic                          pend_q
);
   logic clr_req;
   logic is_fld;

   assign is_fld  = addr[REG_AW-1];
   assign clr_req = we && (addr == ADR_STAT) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         fld_q  <= '0;
      end else if (we) begin
         if (addr == ADR_CTRL) ctrl_q <= ctrl_t'(wdata[3:0]);
         if (is_fld) fld_q[addr[2:0]] <= wdata[CW-1:0];
      end
   end

   // frame-start flag: a new event outranks a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (set_pend) pend_q <= 1'b1;
      else if (clr_req)  pend_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (addr == ADR_CTRL)      rdata[3:0]    = ctrl_q;
      else if (addr == ADR_STAT) rdata[1:0]    = {running, pend_q};
      else if (is_fld)           rdata[CW-1:0] = fld_q[addr[2:0]];
   end

   p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_pend |=> pend_q);
   p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_pend) |=> !pend_q);
   p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_req && !set_pend) |=> $stable(pend_q));
endmodule

// File: rtl/vtg_limits.sv
module vtg_limits #(
   parameter int unsigned CW        = 12,
   parameter int unsigned LW        = CW + 3,
   parameter bit          TV_EN     = 1'b1,
   parameter int unsigned TV_LEAD   = 10,
   parameter int unsigned TV_TAIL   = 92,
   parameter bit          TAIL_FROM_TOTAL = 1'b1
) (
   input  logic [CW-1:0] act_m1,
   input  logic [CW-1:0] fp_m1,
   input  logic [CW-1:0] sw_m1,
   input  logic [CW-1:0] bp_m1,
   input  logic          tv,
   output logic [LW-1:0] act,
   output logic [LW-1:0] sync_beg,
   output logic [LW-1:0] sync_end,
   output logic [LW-1:0] total
);
   localparam int unsigned PADW = LW - CW;
   localparam logic [LW-1:0] ONE = LW'(1);

   logic [LW-1:0] prog_beg, prog_end;

   assign act      = {{PADW{1'b0}}, act_m1} + ONE;
   assign prog_beg = act + {{PADW{1'b0}}, fp_m1} + ONE;
   assign prog_end = prog_beg + {{PADW{1'b0}}, sw_m1} + ONE;
   assign total    = prog_end + {{PADW{1'b0}}, bp_m1} + ONE;

   if (TV_EN) begin : g_tv
      logic [LW-1:0] tv_beg, tv_end;
      assign tv_beg = act + LW'(TV_LEAD);
      if (TAIL_FROM_TOTAL) begin : g_from_total
         assign tv_end = total - LW'(TV_TAIL);
      end else begin : g_from_start
         assign tv_end = tv_beg + LW'(TV_TAIL);
      end
      assign sync_beg = tv ? tv_beg : prog_beg;
      assign sync_end = tv ? tv_end : prog_end;
   end else begin : g_prog_only
      logic unused_tv;
      assign unused_tv = tv;
      assign sync_beg  = prog_beg;
      assign sync_end  = prog_end;
   end
endmodule

// File: rtl/vtg_scan.sv
module vtg_scan #(
   parameter int unsigned LW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_en,
   input  logic          go,
   input  logic [LW-1:0] h_total,
   input  logic [LW-1:0] v_total,
   output logic [LW-1:0] hcnt,
   output logic [LW-1:0] vcnt,
   output logic          running,
   output logic          frame_evt
);
   localparam logic [LW-1:0] ONE = LW'(1);
   logic last_h, last_v;

   assign last_h    = (hcnt == h_total - ONE);
   assign last_v    = (vcnt == v_total - ONE);
   assign frame_evt = running && pix_en && (hcnt == '0) && (vcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt    <= '0;
         vcnt    <= '0;
         running <= 1'b0;
      end else if (!running) begin
         hcnt    <= '0;
         vcnt    <= '0;
         running <= go;
      end else if (pix_en) begin
         if (last_h) begin
            hcnt <= '0;
            if (last_v) begin
               vcnt    <= '0;
               running <= go;   // stop request honoured only here
            end else begin
               vcnt <= vcnt + ONE;
            end
         end else begin
            hcnt <= hcnt + ONE;
         end
      end
   end

   p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (running && pix_en && last_h) |=> (hcnt == '0));
   p_hstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (running && pix_en && !last_h) |=> (hcnt == $past(hcnt) + ONE));
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !pix_en) |=> ($stable(hcnt) && $stable(vcnt) && running));
   p_start_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (hcnt == '0 && vcnt == '0));
   p_stop_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(pix_en && last_h && last_v));
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
   import vtg_pkg::*;
#(
   parameter int unsigned CW        = 12,
   parameter bit          TV_EN     = 1'b1,
   parameter int unsigned TV_H_LEAD = 10,
   parameter int unsigned TV_H_TAIL = 92,
   parameter int unsigned TV_V_LEAD = 1,
   parameter int unsigned TV_V_LEN  = 1,
   localparam int unsigned LW       = CW + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [LW-1:0]     pos_x,
   output logic [LW-1:0]     pos_y,
   output logic              irq
);
   if (CW < 4 || CW > REG_DW) begin : g_bad_cw
      $error("vid_timing_gen: CW must lie in 4..16");
   end
   if (TV_H_LEAD == 0 || TV_V_LEN == 0) begin : g_bad_tv
      $error("vid_timing_gen: TV offsets must be non-zero");
   end

   ctrl_t                     ctrl;
   logic [NFIELD-1:0][CW-1:0] fld;
   logic                      pend, running, frame_evt;
   logic [LW-1:0]             hcnt, vcnt;
   logic [LW-1:0]             h_act, h_beg, h_end, h_tot;
   logic [LW-1:0]             v_act, v_beg, v_end, v_tot;

   vtg_regs #(.CW(CW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .set_pend (frame_evt && ctrl.irq_en),
      .running  (running),
      .ctrl_q   (ctrl),
      .fld_q    (fld),
      .pend_q   (pend)
   );

   vtg_limits #(
      .CW(CW), .LW(LW), .TV_EN(TV_EN),
      .TV_LEAD(TV_H_LEAD), .TV_TAIL(TV_H_TAIL), .TAIL_FROM_TOTAL(1'b1)
   ) u_hlim (
      .act_m1 (fld[F_HACT]), .fp_m1 (fld[F_HFP]),
      .sw_m1  (fld[F_HSW]),  .bp_m1 (fld[F_HBP]),
      .tv     (ctrl.tv_mode),
      .act    (h_act), .sync_beg (h_beg), .sync_end (h_end), .total (h_tot)
   );

   vtg_limits #(
      .CW(CW), .LW(LW), .TV_EN(TV_EN),
      .TV_LEAD(TV_V_LEAD), .TV_TAIL(TV_V_LEN), .TAIL_FROM_TOTAL(1'b0)
   ) u_vlim (
      .act_m1 (fld[F_VACT]), .fp_m1 (fld[F_VFP]),
      .sw_m1  (fld[F_VSW]),  .bp_m1 (fld[F_VBP]),
      .tv     (ctrl.tv_mode),
      .act    (v_act), .sync_beg (v_beg), .sync_end (v_end), .total (v_tot)
   );

   vtg_scan #(.LW(LW)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_en    (pix_en),
      .go        (ctrl.out_en && ctrl.frame_en),
      .h_total   (h_tot),
      .v_total   (v_tot),
      .hcnt      (hcnt),
      .vcnt      (vcnt),
      .running   (running),
      .frame_evt (frame_evt)
   );

   assign de    = running && (hcnt < h_act) && (vcnt < v_act);
   assign hsync = running && (hcnt >= h_beg) && (hcnt < h_end);
   assign vsync = running && (vcnt >= v_beg) && (vcnt < v_end);
   assign pos_x = hcnt;
   assign pos_y = vcnt;
   assign irq   = pend;
endmodule

// File: tb/test_vid_timing_gen.sv
module test_vid_timing_gen;
   localparam int CW = 12;
   localparam int LW = CW + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pix_en = 1'b0;
   logic reg_we = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic hsync, vsync, de, irq;
   logic [LW-1:0] pos_x, pos_y;

   always #10 clk = ~clk;

   vid_timing_gen #(.CW(CW)) i_vid_timing_gen (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .hsync(hsync), .vsync(vsync), .de(de),
      .pos_x(pos_x), .pos_y(pos_y), .irq(irq)
   );

   int checks = 0, fails = 0;
   int hact, hfp, hsw, hbp, vact, vfp, vsw, vbp;
   int htot, vtot, hss, hse, vss, vse, frame, k;
   bit tvm, run_exp, stop_req;
   logic [15:0] rv;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic void calc();
      htot = hact + hfp + hsw + hbp;
      vtot = vact + vfp + vsw + vbp;
      frame = htot * vtot;
      if (tvm) begin
         hss = hact + 10; hse = htot - 92;
         vss = vact + 1;  vse = vact + 2;
      end else begin
         hss = hact + hfp; hse = hss + hsw;
         vss = vact + vfp; vse = vss + vsw;
      end
   endfunction

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      pix_en = 1'b0; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic check_pos();
      int x, y;
      if (!run_exp) begin
         chk("R7", "de idle", int'(de), 0);
         chk("R7", "hsync idle", int'(hsync), 0);
         chk("R7", "vsync idle", int'(vsync), 0);
         chk("R7", "pos_x idle", int'(pos_x), 0);
         chk("R7", "pos_y idle", int'(pos_y), 0);
         return;
      end
      x = k % htot;
      y = (k / htot) % vtot;
      chk("R1", "pos_x", int'(pos_x), x);
      chk("R1", "pos_y", int'(pos_y), y);
      chk("R2", "de", int'(de), int'(x < hact && y < vact));
      chk(tvm ? "R4" : "R3", "hsync", int'(hsync), int'(x >= hss && x < hse));
      chk(tvm ? "R5" : "R3", "vsync", int'(vsync), int'(y >= vss && y < vse));
   endtask

   // advance n pixel steps; pat=p gives one enable every p+1 cycles
   task automatic sweep(int n, int pat);
      int done = 0;
      for (int c = 0; done < n; c++) begin
         bit pe;
         pe = (c % (pat + 1)) == 0;
         pix_en = pe;
         @(posedge clk);
         if (pe) begin
            done++;
            if (run_exp) begin
               k++;
               if (stop_req && (k % frame) == 0) run_exp = 1'b0;
            end
         end
         @(negedge clk);
         pix_en = 1'b0;
         check_pos();
      end
   endtask

   task automatic prog();
      wr(4'd8,  16'(hact - 1)); wr(4'd9,  16'(vact - 1));
      wr(4'd10, 16'(hfp - 1));  wr(4'd11, 16'(vfp - 1));
      wr(4'd12, 16'(hsw - 1));  wr(4'd13, 16'(vsw - 1));
      wr(4'd14, 16'(hbp - 1));  wr(4'd15, 16'(vbp - 1));
      calc();
   endtask

   task automatic start(input logic [3:0] ctl);
      wr(4'd0, {12'd0, ctl});
      rd(4'd1, rv);
      chk("R6", "running before start edge", int'(rv[1]), 0);
      @(negedge clk);
      rd(4'd1, rv);
      chk("R8", "running after start", int'(rv[1]), 1);
      k = 0; run_exp = 1'b1; stop_req = 1'b0;
      check_pos();
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      run_exp = 1'b0; stop_req = 1'b0; k = 0; tvm = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      rd(4'd0, rv); chk("R11", "ctrl after reset", int'(rv), 0);
      rd(4'd1, rv); chk("R11", "status after reset", int'(rv), 0);
      rd(4'd12, rv); chk("R11", "field after reset", int'(rv), 0);
      chk("R9", "irq after reset", int'(irq), 0);
      check_pos();

      // readback and masking
      wr(4'd10, 16'hF123); rd(4'd10, rv); chk("R11", "field mask", int'(rv), 'h123);
      wr(4'd3, 16'hFFFF);  rd(4'd3, rv);  chk("R11", "unmapped", int'(rv), 0);
      wr(4'd0, 16'h0004);  rd(4'd0, rv);  chk("R11", "ctrl readback", int'(rv), 4);

      // one enable alone never starts the scan
      wr(4'd0, 16'h0001);
      sweep(3, 0);
      rd(4'd1, rv); chk("R6", "out_en only", int'(rv[1]), 0);
      wr(4'd0, 16'h0002);
      sweep(3, 0);
      rd(4'd1, rv); chk("R6", "frame_en only", int'(rv[1]), 0);

      // normal mode
      tvm = 1'b0;
      hact = 4; hfp = 2; hsw = 3; hbp = 1;
      vact = 3; vfp = 1; vsw = 2; vbp = 1;
      prog();
      start(4'b1011);
      rd(4'd1, rv); chk("R9", "pending before first step", int'(rv[0]), 0);
      sweep(1, 0);
      rd(4'd1, rv); chk("R9", "pending at frame start", int'(rv[0]), 1);
      chk("R9", "irq follows pending", int'(irq), 1);
      wr(4'd1, 16'h0001);
      rd(4'd1, rv); chk("R9", "pending cleared", int'(rv[0]), 0);
      sweep(2 * frame - 1, 1);

      // set and clear in the same cycle at pos (0,0)
      chk("R10", "at origin x", int'(pos_x), 0);
      @(negedge clk);
      pix_en = 1'b1; reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 16'h0001;
      @(posedge clk);
      k++;
      @(negedge clk);
      pix_en = 1'b0; reg_we = 1'b0;
      rd(4'd1, rv); chk("R10", "set beats clear", int'(rv[0]), 1);
      check_pos();
      wr(4'd1, 16'h0000);
      rd(4'd1, rv); chk("R9", "write 0 keeps pending", int'(rv[0]), 1);
      wr(4'd1, 16'h0001);
      rd(4'd1, rv); chk("R9", "write 1 clears", int'(rv[0]), 0);

      // stop request mid-frame
      sweep(5, 2);
      wr(4'd0, 16'h000A);
      stop_req = 1'b1;
      sweep(frame - (k % frame) - 1, 0);
      rd(4'd1, rv); chk("R8", "running in last pixel", int'(rv[1]), 1);
      sweep(1, 0);
      rd(4'd1, rv); chk("R8", "stopped at boundary", int'(rv[1]), 0);
      sweep(4, 0);
      rd(4'd1, rv); chk("R7", "stays stopped", int'(rv[1]), 0);

      // TV mode, interrupt disabled
      wr(4'd1, 16'h0001);
      tvm = 1'b1;
      hact = 8; hfp = 20; hsw = 30; hbp = 100;
      vact = 3; vfp = 3; vsw = 2; vbp = 1;
      prog();
      start(4'b0111);
      sweep(frame + 20, 0);
      sweep(frame, 2);
      rd(4'd1, rv); chk("R9", "no pending when irq disabled", int'(rv[0]), 0);
      chk("R9", "irq low when disabled", int'(irq), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule